// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit virtual address into a physical address by fetching two dependent page table entries from memory. A requester presents a virtual address together with the base of the top-level table. The walker reads the top-level (directory) entry and, if it is valid, uses that entry's frame as the base of a second-level table. It then reads the leaf entry and joins the leaf frame number with the untouched 12-bit page offset. If either entry has its valid bit clear, the walk stops and a fault is reported, along with the level at which it stopped.

The address splits 10/10/12: bits 31:22 index the directory, bits 21:12 index the second-level table, and bits 11:0 are the byte offset within a 4 KB page. Entries are 4 bytes wide, so each table is exactly one page of 1024 entries. In an entry, bits 31:12 carry the frame number and bit 0 is the valid flag. Bit 1 (writable) and bits 11:2 (reserved) play no part in the walk. Memory is reached through a valid/ready read request channel and a response channel with a single data strobe. Only one walk is in flight at a time.

The sequencer has six states. IDLE accepts a request (IDLE→ISSUE_L1). ISSUE_L1 offers the directory read until it is taken (→AWAIT_L1). AWAIT_L1 waits for the directory data and goes to ISSUE_L2 on a valid entry or to REPORT on an invalid one. ISSUE_L2 offers the leaf read (→AWAIT_L2). AWAIT_L2 waits for the leaf data (→REPORT). REPORT presents the result for one cycle (→IDLE).

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `done_valid` are 0.
- R2: The first read of a walk goes to `req_root + 4 * vaddr[31:22]`.
- R3: The second read goes only after a valid directory entry has arrived, to `{dir_entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R4: On a valid leaf, `done_valid` pulses for exactly one cycle with `done_fault` = 0 and `done_paddr = {leaf[31:12], vaddr[11:0]}`.
- R5: A directory entry with bit 0 = 0 ends the walk with `done_fault` = 1, `done_level` = 0 and `done_paddr` = 0, and no second read is issued.
- R6: A leaf entry with bit 0 = 0 ends the walk with `done_fault` = 1, `done_level` = 1 and `done_paddr` = 0.
- R7: Entry bits 11:1 (the writable flag and the reserved bits) change neither the fault decision nor the physical address.
- R8: `req_ready` is high only in IDLE. A request presented during a walk is not taken and does not alter the walk in progress.
- R9: A read request stays asserted with a stable address until `mem_req_ready`. Any number of stall cycles on the request channel or the response channel yields the same result.
- R10: At most one read is outstanding. `mem_req_valid` stays low from a read's acceptance until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 32 | Byte address of the directory table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done_valid | output | 1 | One-cycle result strobe |
| done_fault | output | 1 | Walk ended on an invalid entry |
| done_level | output | 1 | Level of the invalid entry (0 directory, 1 leaf) |
| done_paddr | output | 32 | Translated physical address, 0 on fault |

## Verification
The bench sweeps every directory index under two table bases, with varied second-level indices and offsets, against a memory whose entries are computed from their address. The valid bits form a sparse pattern, and the reserved and writable bits are noisy. A walker that took its base from the wrong level, or scaled an index by anything other than four, would read the wrong addresses and return mismatched frames. One that ignored a cleared valid bit would report a translation where a fault belongs, or go on to issue a stray second read. The sweep varies request-channel stalls and response latency, and injects requests in the middle of a walk. This exposes a walker that drops its request before it is taken, consumes data in the wrong state, accepts new work while busy, or holds its result for more than one cycle.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_L1,
        ST_AWAIT_L1,
        ST_ISSUE_L2,
        ST_AWAIT_L2,
        ST_REPORT
    } walk_state_t;

endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0] vaddr,
    output logic [IDX_W-1:0]  idx_dir,
    output logic [IDX_W-1:0]  idx_leaf,
    output logic [OFF_W-1:0]  offset
);
    localparam int LEAF_LO = OFF_W;
    localparam int DIR_LO  = OFF_W + IDX_W;

    assign offset   = vaddr[OFF_W-1:0];
    assign idx_leaf = vaddr[LEAF_LO +: IDX_W];
    assign idx_dir  = vaddr[DIR_LO  +: IDX_W];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 10,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);

    logic [ADDR_W-1:0] scaled;

    assign scaled     = ADDR_W'(index) << SHIFT;
    assign entry_addr = table_base + scaled;
endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode #(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [DATA_W-1:0]       pte,
    output logic                    valid,
    output logic [DATA_W-OFF_W-1:0] frame
);
    logic unused_flag_bits;

    assign valid            = pte[0];
    assign frame            = pte[DATA_W-1:OFF_W];
    assign unused_flag_bits = ^pte[OFF_W-1:1];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 10,
    parameter int OFF_W       = 12,
    parameter int ENTRY_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [ADDR_W-1:0] req_root,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              done_valid,
    output logic              done_fault,
    output logic              done_level,
    output logic [ADDR_W-1:0] done_paddr
);
    localparam int FRAME_W = ADDR_W - OFF_W;

    walk_state_t        state_q, state_nx;
    logic [ADDR_W-1:0]  va_q, root_q;
    logic [FRAME_W-1:0] l2_frame_q, leaf_frame_q;
    logic               fault_q, level_q;

    logic [IDX_W-1:0]   idx_dir, idx_leaf;
    logic [OFF_W-1:0]   pg_off;
    logic               rsp_ok;
    logic [FRAME_W-1:0] rsp_frame;
    logic [ADDR_W-1:0]  tbl_base;
    logic [IDX_W-1:0]   tbl_idx;

    pt_va_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
        .vaddr    (va_q),
        .idx_dir  (idx_dir),
        .idx_leaf (idx_leaf),
        .offset   (pg_off)
    );

    pt_pte_decode #(.DATA_W(ADDR_W), .OFF_W(OFF_W)) u_decode (
        .pte   (mem_rsp_data),
        .valid (rsp_ok),
        .frame (rsp_frame)
    );

    // Second-level reads use the frame from the directory entry as table base.
    always_comb begin
        if (state_q == ST_ISSUE_L2) begin
            tbl_base = {l2_frame_q, {OFF_W{1'b0}}};
            tbl_idx  = idx_leaf;
        end else begin
            tbl_base = root_q;
            tbl_idx  = idx_dir;
        end
    end

    pt_entry_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENTRY_BYTES(ENTRY_BYTES)) u_eaddr (
        .table_base (tbl_base),
        .index      (tbl_idx),
        .entry_addr (mem_req_addr)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)     state_nx = ST_ISSUE_L1;
            ST_ISSUE_L1: if (mem_req_ready) state_nx = ST_AWAIT_L1;
            ST_AWAIT_L1: if (mem_rsp_valid) state_nx = rsp_ok ? ST_ISSUE_L2 : ST_REPORT;
            ST_ISSUE_L2: if (mem_req_ready) state_nx = ST_AWAIT_L2;
            ST_AWAIT_L2: if (mem_rsp_valid) state_nx = ST_REPORT;
            ST_REPORT:                      state_nx = ST_IDLE;
            default:                        state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Walk context captured along the way
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q         <= '0;
            root_q       <= '0;
            l2_frame_q   <= '0;
            leaf_frame_q <= '0;
            fault_q      <= 1'b0;
            level_q      <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                va_q    <= req_vaddr;
                root_q  <= req_root;
                fault_q <= 1'b0;
                level_q <= 1'b0;
            end
            if (state_q == ST_AWAIT_L1 && mem_rsp_valid) begin
                l2_frame_q <= rsp_frame;
                if (!rsp_ok) begin
                    fault_q <= 1'b1;
                    level_q <= 1'b0;
                end
            end
            if (state_q == ST_AWAIT_L2 && mem_rsp_valid) begin
                leaf_frame_q <= rsp_frame;
                if (!rsp_ok) begin
                    fault_q <= 1'b1;
                    level_q <= 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        done_valid    = 1'b0;
        done_fault    = 1'b0;
        done_level    = 1'b0;
        done_paddr    = '0;
        unique case (state_q)
            ST_IDLE:     req_ready     = 1'b1;
            ST_ISSUE_L1: mem_req_valid = 1'b1;
            ST_ISSUE_L2: mem_req_valid = 1'b1;
            ST_REPORT: begin
                done_valid = 1'b1;
                done_fault = fault_q;
                done_level = fault_q & level_q;
                if (!fault_q) done_paddr = {leaf_frame_q, pg_off};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              done_valid,
    input logic              done_fault,
    input logic [ADDR_W-1:0] done_paddr
);
    logic outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              outstanding <= 1'b0;
        else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
        else if (mem_rsp_valid)                  outstanding <= 1'b0;
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req_valid);

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_fault_no_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && done_fault |-> done_paddr == '0);

    assert_accept_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req_valid && !req_ready);

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid || done_valid |-> !req_ready);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_pt_walker_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_paddr    (done_paddr)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic        done_fault;
    logic        done_level;
    logic [31:0] done_paddr;

    int n_chk = 0;
    int n_fail = 0;

    // memory model control, shared with the walk task
    int          lat = 0;
    int          rdy_div = 1;
    int          hs = 0;
    logic [31:0] exp_a1 = '0;
    logic [31:0] exp_a2 = '0;
    bit          pend = 1'b0;
    int          cnt = 0;
    int          cyc = 0;
    logic [31:0] pend_addr = '0;

    localparam logic [31:0] ROOT_A = 32'h0004_0000;
    localparam logic [31:0] ROOT_B = 32'h0008_0000;

    always #2.5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_root      (req_root),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .done_valid    (done_valid),
        .done_fault    (done_fault),
        .done_level    (done_level),
        .done_paddr    (done_paddr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Entry word = {frame[19:0], noise[9:0], writable, valid}, computed from address
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [19:0] fr, nf;
        logic [9:0]  ix;
        logic        v, w;
        fr = a[31:12];
        ix = a[11:2];
        if (fr == ROOT_A[31:12]) begin
            nf = 20'h00100 + 20'(ix);
            v  = (ix % 7) != 3;
            w  = ix[0];
        end else if (fr == ROOT_B[31:12]) begin
            nf = 20'h00600 + 20'(ix);
            v  = (ix % 11) != 5;
            w  = ~ix[0];
        end else begin
            nf = (fr * 20'd977 + 20'(ix) * 20'd31) ^ 20'h5A5A5;
            v  = ((32'(fr) + 32'(ix)) % 9) != 4;
            w  = fr[0];
        end
        return {nf, ix, w, v};
    endfunction

    // Memory: request channel stalls by rdy_div, response after lat cycles
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_word(pend_addr);
                    pend = 1'b0;
                end else begin
                    cnt--;
                end
            end
            mem_req_ready = rst_n && !pend && !mem_rsp_valid && ((cyc % rdy_div) == 0);
            if (mem_req_valid && mem_req_ready) begin
                pend = 1'b1;
                cnt = lat;
                pend_addr = mem_req_addr;
                hs++;
                if (hs == 1)
                    chk(mem_req_addr == exp_a1, "R2 directory read address", mem_req_addr, exp_a1);
                else
                    chk(mem_req_addr == exp_a2 && hs == 2, "R3 leaf read address", mem_req_addr, exp_a2);
            end
        end
    end

    task automatic walk(input logic [31:0] root, input logic [31:0] va,
                        input int lt, input int rd, input bit poke);
        logic [31:0] m, s, exp_pa;
        bit          exp_fault, exp_lvl;
        int          exp_hs, n;
        exp_a1 = root + {20'b0, va[31:22], 2'b00};
        m = mem_word(exp_a1);
        exp_a2 = '0;
        if (!m[0]) begin
            exp_fault = 1'b1; exp_lvl = 1'b0; exp_pa = '0; exp_hs = 1;
        end else begin
            exp_a2 = {m[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
            s = mem_word(exp_a2);
            exp_hs = 2;
            if (!s[0]) begin
                exp_fault = 1'b1; exp_lvl = 1'b1; exp_pa = '0;
            end else begin
                exp_fault = 1'b0; exp_lvl = 1'b0; exp_pa = {s[31:12], va[11:0]};
            end
        end
        hs = 0;
        lat = lt;
        rdy_div = rd;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready in idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_root  = root;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            req_valid = 1'b1;
            req_vaddr = ~va;
            req_root  = (root == ROOT_A) ? ROOT_B : ROOT_A;
            chk(req_ready == 1'b0, "R8 busy not ready", 32'(req_ready), 32'd0);
            @(negedge clk);
            req_valid = 1'b0;
        end
        n = 0;
        while (!done_valid && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk(done_valid == 1'b1, "R9 walk completes", 32'(done_valid), 32'd1);
        chk(done_fault == exp_fault, exp_lvl ? "R6 fault flag" : "R5 fault flag",
            32'(done_fault), 32'(exp_fault));
        if (exp_fault)
            chk(done_level == exp_lvl, exp_lvl ? "R6 fault level" : "R5 fault level",
                32'(done_level), 32'(exp_lvl));
        chk(done_paddr == exp_pa, "R4 R7 physical address", done_paddr, exp_pa);
        chk(hs == exp_hs, "R5 R10 number of reads", 32'(hs), 32'(exp_hs));
        @(negedge clk);
        chk(done_valid == 1'b0, "R4 done single pulse", 32'(done_valid), 32'd0);
        chk(req_ready == 1'b1, "R8 back to idle", 32'(req_ready), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(mem_req_valid == 1'b0, "R1 no read in reset", 32'(mem_req_valid), 32'd0);
        chk(done_valid == 1'b0, "R1 no result in reset", 32'(done_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && done_valid == 1'b0,
            "R1 idle after reset release", {29'b0, req_ready, mem_req_valid, done_valid}, 32'h4);

        // corner addresses
        walk(ROOT_A, 32'h0000_0000, 0, 1, 1'b0);
        walk(ROOT_A, 32'hFFFF_FFFF, 0, 1, 1'b0);
        walk(ROOT_B, 32'hFFFF_FFFF, 3, 2, 1'b1);
        // long stalls on both channels
        walk(ROOT_A, 32'h1234_5678, 20, 5, 1'b0);

        // sweep of every directory index under both roots
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 1024; i++) begin
                logic [31:0] va;
                va = {10'(i), 10'((i * 37 + r * 101) % 1024), 12'((i * 13 + r * 7) % 4096)};
                walk(r == 0 ? ROOT_A : ROOT_B, va, i % 4, 1 + (i % 3), (i % 16) == 0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule